// File: doc/BRIEF.md
# DMA Host Register Interface

This block is the processor-facing programming port of a four-channel DMA engine. A host reaches it over an 8-bit data bus, a 4-bit register address, an active-low chip select and separate active-low read and write strobes, all sampled on the block clock. Through this port the host loads each channel's 16-bit start address and 14-bit transfer count, sets the global operating mode, and polls the per-channel terminal-count status.

Each channel register is wider than the bus, so it is reached as two bytes in sequence. A single byte-pointer flip-flop selects the low byte when clear and the high byte when set, and flips after every channel-register access. Writing the mode register returns the pointer to the low byte, so host software can resynchronise it at any time. Programmed values, mode fields and per-register load pulses are driven out to the channel datapaths and the arbiter, which live outside this block. Terminal-count pulses from the channels are collected here and reported in the status byte.

Top module: `dmahr_top`

## Requirements
- R1: After reset the mode register, the byte pointer, all terminal-count flags and all channel address and count registers are zero.
- R2: With address bit 3 clear, bits 2..1 pick the channel and bit 0 picks its address register (0) or count register (1). Address 1000 writes the mode register and reads the status byte.
- R3: The byte pointer selects the low byte when 0 and the high byte when 1. It flips once after each channel-register write and once after each channel-register read completes.
- R4: Any write to the mode register clears the byte pointer.
- R5: A write to the high byte of a count register keeps only data bits 5..0. Reading that byte returns bits 7..6 as zero.
- R6: Mode bits 7 to 0 drive, in order, auto-load, stop-on-terminal-count, extended write, rotating priority, and the enables of channels 3, 2, 1 and 0.
- R7: Status bits 7..5 read zero, bit 4 reflects the update-cycle input, and bits 3..0 are per-channel terminal-count flags. A flag sets on a pulse of `tc_set` and clears only after a status read completes, and that read leaves bit 4 untouched.
- R8: While `cs_n` is high, strobes have no effect: nothing is written, `rdata` stays zero and the pointer does not move.
- R9: Addresses 1001 to 1111 are unused. Writes to them change no register and do not move the pointer, and reads return zero.
- R10: Writing the high byte of a channel's address (or count) register pulses that channel's bit of `ld_addr` (or `ld_cnt`) for one cycle, in the cycle after the write takes effect.
- R11: `rdata` is zero whenever no selected read is in progress.
- R12: One assertion of a write strobe is one write: holding `wr_n` low for several cycles stores the byte once and moves the pointer once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| reg_addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero when not reading |
| tc_set | input | 4 | Per-channel terminal-count pulses from the datapaths |
| upd_busy | input | 1 | Update cycle in progress, reported in status bit 4 |
| cfg_autoload | output | 1 | Mode: auto-load |
| cfg_tc_stop | output | 1 | Mode: disable channel after terminal count |
| cfg_ext_write | output | 1 | Mode: extended write |
| cfg_rotate | output | 1 | Mode: rotating priority |
| cfg_ch_en | output | 4 | Mode: per-channel enables |
| ch_base_addr | output | 64 | Programmed addresses, channel n at bits 16n+15..16n |
| ch_base_cnt | output | 56 | Programmed counts, channel n at bits 14n+13..14n |
| ld_addr | output | 4 | One-cycle pulse after an address high byte is written |
| ld_cnt | output | 4 | One-cycle pulse after a count high byte is written |

## Verification
The assertions assume a host that never asserts `rd_n` and `wr_n` together. They also assume that `reg_addr` and `wdata` stay steady for the whole of a strobe, that `tc_set` is a single-cycle pulse, and that each strobe is released for at least one cycle before the next. The stimulus tasks keep to these rules. Each task drives the bus on a falling clock edge, holds it for one cycle or more, then releases both strobes and chip select together and leaves one idle cycle. Terminal-count pulses arrive only between bus accesses.

// File: rtl/dmahr_pkg.sv
package dmahr_pkg;

   // Mode byte, packed from bit 7 down to bit 0.
   typedef struct packed {
      logic       autoload;
      logic       tc_stop;
      logic       ext_write;
      logic       rotate;
      logic [3:0] ch_en;
   } dmahr_mode_t;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CHAN = 2'd1,
      SEL_MODE = 2'd2
   } dmahr_sel_e;

endpackage

// File: rtl/dmahr_bus_if.sv
module dmahr_bus_if (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_act,
   output logic wr_evt,
   output logic rd_end
);

   logic wr_act;
   logic wr_act_q;
   logic rd_act_q;

   assign wr_act = ~cs_n & ~wr_n;
   assign rd_act = ~cs_n & ~rd_n;
   assign wr_evt = wr_act & ~wr_act_q;
   assign rd_end = rd_act_q & ~rd_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
      end
   end

   AST_ONE_WRITE_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
      wr_evt |=> !wr_evt); // R12

endmodule

// File: rtl/dmahr_chan_bank.sv
module dmahr_chan_bank #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 14,
   parameter int DATA_W = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int CHI_W = CNT_W - DATA_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     chan_we,
   input  logic [CH_W-1:0]          sel_ch,
   input  logic                     sel_cnt,
   input  logic                     hi_byte,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rd_byte,
   output logic [NUM_CH*ADDR_W-1:0] addr_flat,
   output logic [NUM_CH*CNT_W-1:0]  cnt_flat,
   output logic [NUM_CH-1:0]        ld_addr,
   output logic [NUM_CH-1:0]        ld_cnt
);

   logic [NUM_CH*DATA_W-1:0] cnt_hi_flat;
   logic [NUM_CH-1:0]        ld_addr_nxt;
   logic [NUM_CH-1:0]        ld_cnt_nxt;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [ADDR_W-1:0] a_q;
      logic [CNT_W-1:0]  c_q;
      logic              hit;

      assign hit = chan_we && (sel_ch == CH_W'(i));

      always_ff @(posedge clk) begin
         if (rst) begin
            a_q <= '0;
         end else if (hit && !sel_cnt) begin
            if (hi_byte) a_q[ADDR_W-1:DATA_W] <= wdata;
            else         a_q[DATA_W-1:0]      <= wdata;
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            c_q <= '0;
         end else if (hit && sel_cnt) begin
            if (hi_byte) c_q[CNT_W-1:DATA_W] <= wdata[CHI_W-1:0];
            else         c_q[DATA_W-1:0]     <= wdata;
         end
      end

      // Count high byte is narrower than the bus unless CNT_W = 2*DATA_W.
      if (CHI_W < DATA_W) begin : g_pad
         assign cnt_hi_flat[i*DATA_W +: DATA_W] =
            {{(DATA_W-CHI_W){1'b0}}, c_q[CNT_W-1:DATA_W]};
      end else begin : g_full
         assign cnt_hi_flat[i*DATA_W +: DATA_W] = c_q[CNT_W-1:DATA_W];
      end

      assign addr_flat[i*ADDR_W +: ADDR_W] = a_q;
      assign cnt_flat[i*CNT_W +: CNT_W]    = c_q;
      assign ld_addr_nxt[i] = hit && !sel_cnt && hi_byte;
      assign ld_cnt_nxt[i]  = hit &&  sel_cnt && hi_byte;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ld_addr <= '0;
         ld_cnt  <= '0;
      end else begin
         ld_addr <= ld_addr_nxt;
         ld_cnt  <= ld_cnt_nxt;
      end
   end

   always_comb begin
      rd_byte = '0;
      if (sel_cnt) begin
         if (hi_byte) rd_byte = cnt_hi_flat[sel_ch*DATA_W +: DATA_W];
         else         rd_byte = cnt_flat[sel_ch*CNT_W +: DATA_W];
      end else begin
         if (hi_byte) rd_byte = addr_flat[sel_ch*ADDR_W+DATA_W +: DATA_W];
         else         rd_byte = addr_flat[sel_ch*ADDR_W +: DATA_W];
      end
   end

   AST_LOAD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ld_cnt, ld_addr})); // R10
   AST_LOAD_AFTER_HI_WRITE: assert property (@(posedge clk) disable iff (rst)
      (|{ld_cnt, ld_addr}) |-> ($past(chan_we) && $past(hi_byte))); // R10

endmodule

// File: rtl/dmahr_status.sv
module dmahr_status #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] tc_set,
   input  logic              clr,
   output logic [NUM_CH-1:0] tc_flags
);

   always_ff @(posedge clk) begin
      if (rst) tc_flags <= '0;
      else     tc_flags <= (tc_flags & ~{NUM_CH{clr}}) | tc_set;
   end

   AST_TC_CAPTURED: assert property (@(posedge clk) disable iff (rst)
      (|tc_set) |=> ((tc_flags & $past(tc_set)) == $past(tc_set))); // R7
   AST_TC_HELD: assert property (@(posedge clk) disable iff (rst)
      (!clr && (|tc_flags)) |=> ((tc_flags & $past(tc_flags)) == $past(tc_flags))); // R7

endmodule

// File: rtl/dmahr_top.sv
module dmahr_top
   import dmahr_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 14,
   parameter int DATA_W = 8,
   parameter int REG_AW = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cs_n,
   input  logic                     rd_n,
   input  logic                     wr_n,
   input  logic [REG_AW-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic [NUM_CH-1:0]        tc_set,
   input  logic                     upd_busy,
   output logic                     cfg_autoload,
   output logic                     cfg_tc_stop,
   output logic                     cfg_ext_write,
   output logic                     cfg_rotate,
   output logic [NUM_CH-1:0]        cfg_ch_en,
   output logic [NUM_CH*ADDR_W-1:0] ch_base_addr,
   output logic [NUM_CH*CNT_W-1:0]  ch_base_cnt,
   output logic [NUM_CH-1:0]        ld_addr,
   output logic [NUM_CH-1:0]        ld_cnt
);

   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [REG_AW-1:0] CHAN_LIMIT = REG_AW'(2*NUM_CH);
   localparam logic [REG_AW-1:0] MODE_ADDR  = REG_AW'(2*NUM_CH);
   localparam int STAT_PAD = DATA_W - NUM_CH - 1;

   // Elaboration checks: fixed mode/status layout and byte-pair access.
   if (NUM_CH != 4) begin : g_bad_ch
      $error("dmahr_top: mode and status layouts need NUM_CH = 4");
   end
   if (ADDR_W != 2*DATA_W) begin : g_bad_aw
      $error("dmahr_top: ADDR_W must be two bus bytes");
   end
   if (CNT_W <= DATA_W || CNT_W > 2*DATA_W) begin : g_bad_cw
      $error("dmahr_top: CNT_W must span more than one and at most two bytes");
   end
   if (REG_AW < CH_W + 2) begin : g_bad_ra
      $error("dmahr_top: REG_AW too small for the register map");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("dmahr_top: the mode byte is eight bits wide");
   end

   logic        rd_act, wr_evt, rd_end;
   dmahr_sel_e  sel;
   logic        ptr_q;
   logic        rd_chan_q, rd_stat_q;
   dmahr_mode_t mode_q;
   logic [DATA_W-1:0] chan_byte;
   logic [NUM_CH-1:0] tc_flags;
   logic [DATA_W-1:0] stat_byte;

   dmahr_bus_if u_bus (
      .clk    (clk),
      .rst    (rst),
      .cs_n   (cs_n),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .rd_act (rd_act),
      .wr_evt (wr_evt),
      .rd_end (rd_end)
   );

   always_comb begin
      if (reg_addr < CHAN_LIMIT)      sel = SEL_CHAN;
      else if (reg_addr == MODE_ADDR) sel = SEL_MODE;
      else                            sel = SEL_NONE;
   end

   // Remember what the current read targets; the strobe may end after the address moves.
   always_ff @(posedge clk) begin
      if (rst) begin
         rd_chan_q <= 1'b0;
         rd_stat_q <= 1'b0;
      end else if (rd_act) begin
         rd_chan_q <= (sel == SEL_CHAN);
         rd_stat_q <= (sel == SEL_MODE);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         ptr_q <= 1'b0;
      else if (wr_evt && sel == SEL_MODE)
         ptr_q <= 1'b0;
      else if ((wr_evt && sel == SEL_CHAN) || (rd_end && rd_chan_q))
         ptr_q <= ~ptr_q;
   end

   always_ff @(posedge clk) begin
      if (rst)                           mode_q <= '0;
      else if (wr_evt && sel == SEL_MODE) mode_q <= dmahr_mode_t'(wdata);
   end

   dmahr_chan_bank #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .chan_we   (wr_evt && sel == SEL_CHAN),
      .sel_ch    (reg_addr[CH_W:1]),
      .sel_cnt   (reg_addr[0]),
      .hi_byte   (ptr_q),
      .wdata     (wdata),
      .rd_byte   (chan_byte),
      .addr_flat (ch_base_addr),
      .cnt_flat  (ch_base_cnt),
      .ld_addr   (ld_addr),
      .ld_cnt    (ld_cnt)
   );

   dmahr_status #(
      .NUM_CH (NUM_CH)
   ) u_stat (
      .clk      (clk),
      .rst      (rst),
      .tc_set   (tc_set),
      .clr      (rd_end && rd_stat_q),
      .tc_flags (tc_flags)
   );

   assign stat_byte = {{STAT_PAD{1'b0}}, upd_busy, tc_flags};

   always_comb begin
      rdata = '0;
      if (rd_act) begin
         if (sel == SEL_CHAN)      rdata = chan_byte;
         else if (sel == SEL_MODE) rdata = stat_byte;
      end
   end

   assign cfg_autoload  = mode_q.autoload;
   assign cfg_tc_stop   = mode_q.tc_stop;
   assign cfg_ext_write = mode_q.ext_write;
   assign cfg_rotate    = mode_q.rotate;
   assign cfg_ch_en     = mode_q.ch_en;

   AST_PTR_CLEARED_BY_MODE: assert property (@(posedge clk) disable iff (rst)
      (wr_evt && sel == SEL_MODE) |=> !ptr_q); // R4
   AST_PTR_FLIPS_ON_CHAN: assert property (@(posedge clk) disable iff (rst)
      (wr_evt && sel == SEL_CHAN) |=> (ptr_q != $past(ptr_q))); // R3
   AST_NOCS_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
      (cs_n && $past(cs_n)) |=> ($stable(mode_q) && $stable(ptr_q))); // R8
   AST_CNT_HI_PADDED: assert property (@(posedge clk) disable iff (rst)
      (rd_act && sel == SEL_CHAN && reg_addr[0] && ptr_q) |-> (rdata[DATA_W-1:CNT_W-DATA_W] == '0)); // R5
   AST_STATUS_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_act && sel == SEL_MODE) |-> (rdata[DATA_W-1:NUM_CH+1] == '0)); // R7
   AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_act && sel == SEL_NONE) |-> (rdata == '0)); // R9

endmodule

// File: tb/tb_dmahr_top.sv
module tb_dmahr_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        cs_n, rd_n, wr_n;
   logic [3:0]  reg_addr;
   logic [7:0]  wdata;
   logic [7:0]  rdata;
   logic [3:0]  tc_set;
   logic        upd_busy;
   logic        cfg_autoload, cfg_tc_stop, cfg_ext_write, cfg_rotate;
   logic [3:0]  cfg_ch_en;
   logic [63:0] ch_base_addr;
   logic [55:0] ch_base_cnt;
   logic [3:0]  ld_addr, ld_cnt;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dmahr_top dut (
      .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
      .reg_addr (reg_addr), .wdata (wdata), .rdata (rdata),
      .tc_set (tc_set), .upd_busy (upd_busy),
      .cfg_autoload (cfg_autoload), .cfg_tc_stop (cfg_tc_stop),
      .cfg_ext_write (cfg_ext_write), .cfg_rotate (cfg_rotate),
      .cfg_ch_en (cfg_ch_en), .ch_base_addr (ch_base_addr),
      .ch_base_cnt (ch_base_cnt), .ld_addr (ld_addr), .ld_cnt (ld_cnt)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input int hold,
                            output logic [3:0] la, output logic [3:0] lc);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; reg_addr = a; wdata = d;
      @(negedge clk);
      la = ld_addr; lc = ld_cnt;
      for (int k = 1; k < hold; k++) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      logic [3:0] la, lc;
      bus_write(a, d, 1, la, lc);
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; reg_addr = a;
      #1 d = rdata;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
   endtask

   // {write, addr, data, expected read}
   localparam int NV = 24;
   localparam logic [20:0] VEC [NV] = '{
      {1'b1, 4'h0, 8'h34, 8'h00}, {1'b1, 4'h0, 8'h12, 8'h00},
      {1'b0, 4'h0, 8'h00, 8'h34}, {1'b0, 4'h0, 8'h00, 8'h12},
      {1'b1, 4'h1, 8'hFF, 8'h00}, {1'b1, 4'h1, 8'hFF, 8'h00},
      {1'b0, 4'h1, 8'h00, 8'hFF}, {1'b0, 4'h1, 8'h00, 8'h3F},
      {1'b1, 4'h6, 8'hCD, 8'h00}, {1'b1, 4'h6, 8'hAB, 8'h00},
      {1'b1, 4'h7, 8'h10, 8'h00}, {1'b1, 4'h7, 8'hC2, 8'h00},
      {1'b0, 4'h6, 8'h00, 8'hCD}, {1'b0, 4'h6, 8'h00, 8'hAB},
      {1'b0, 4'h7, 8'h00, 8'h10}, {1'b0, 4'h7, 8'h00, 8'h02},
      {1'b1, 4'h2, 8'h55, 8'h00}, {1'b1, 4'h2, 8'h66, 8'h00},
      {1'b0, 4'h2, 8'h00, 8'h55}, {1'b0, 4'h2, 8'h00, 8'h66},
      {1'b0, 4'h0, 8'h00, 8'h34}, {1'b0, 4'h0, 8'h00, 8'h12},
      {1'b0, 4'h1, 8'h00, 8'hFF}, {1'b0, 4'h1, 8'h00, 8'h3F}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [3:0] la, lc;
      rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      reg_addr = '0; wdata = '0; tc_set = '0; upd_busy = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      check("R1 mode", {cfg_autoload, cfg_tc_stop, cfg_ext_write, cfg_rotate, cfg_ch_en}, 8'h00);
      check("R1 regs", {ch_base_addr, ch_base_cnt}, '0);
      rd(4'h8, d); check("R1 status", d, 8'h00);
      rd(4'h0, d); check("R1 addr lo", d, 8'h00);
      rd(4'h0, d); check("R1 addr hi", d, 8'h00);
      check("R11 idle rdata", rdata, 8'h00);

      // R2 R3 R5 vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
         else begin
            rd(VEC[i][19:16], d);
            check("R2/R3/R5 vector", d, VEC[i][7:0]);
         end
      end
      check("R2 ch3 addr port", ch_base_addr[63:48], 16'hABCD);
      check("R5 ch3 count port", ch_base_cnt[55:42], 14'h0210);

      // R6 mode layout
      wr(4'h8, 8'hA5);
      check("R6 mode fields", {cfg_autoload, cfg_tc_stop, cfg_ext_write, cfg_rotate, cfg_ch_en}, 8'hA5);

      // R4 mode write clears pointer
      wr(4'h4, 8'h11);
      wr(4'h8, 8'h0F);
      wr(4'h4, 8'h22);
      wr(4'h4, 8'h33);
      rd(4'h4, d); check("R4 lo after mode write", d, 8'h22);
      rd(4'h4, d); check("R4 hi after mode write", d, 8'h33);

      // R8 chip select high
      @(negedge clk);
      wr_n = 1'b0; reg_addr = 4'h4; wdata = 8'h99;
      @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
      #1 check("R8 rdata with cs_n high", rdata, 8'h00);
      @(negedge clk); rd_n = 1'b1;
      @(negedge clk);
      rd(4'h4, d); check("R8 lo unchanged", d, 8'h22);
      rd(4'h4, d); check("R8 hi unchanged", d, 8'h33);

      // R9 unused addresses
      wr(4'h9, 8'h77);
      wr(4'hF, 8'h00);
      rd(4'hB, d); check("R9 unused read", d, 8'h00);
      rd(4'h4, d); check("R9 pointer not moved", d, 8'h22);
      rd(4'h4, d);
      check("R9 mode unchanged", {cfg_autoload, cfg_tc_stop, cfg_ext_write, cfg_rotate, cfg_ch_en}, 8'h0F);

      // R7 status flags
      upd_busy = 1'b1;
      @(negedge clk); tc_set = 4'b1010;
      @(negedge clk); tc_set = 4'b0000;
      @(negedge clk);
      rd(4'h8, d); check("R7 status with flags", d, 8'h1A);
      rd(4'h8, d); check("R7 flags cleared, update kept", d, 8'h10);
      upd_busy = 1'b0;
      rd(4'h8, d); check("R7 update follows input", d, 8'h00);

      // R10 load strobes
      bus_write(4'h4, 8'h01, 1, la, lc); check("R10 no pulse on lo", {la, lc}, 8'h00);
      bus_write(4'h4, 8'h02, 1, la, lc); check("R10 addr pulse ch2", {la, lc}, 8'h40);
      bus_write(4'h7, 8'h03, 1, la, lc);
      bus_write(4'h7, 8'h04, 1, la, lc); check("R10 count pulse ch3", {la, lc}, 8'h08);
      check("R10 pulse ends", {ld_addr, ld_cnt}, 8'h00);

      // R12 long write strobe
      bus_write(4'h4, 8'h5A, 3, la, lc);
      wr(4'h4, 8'hA5);
      rd(4'h4, d); check("R12 held write lo", d, 8'h5A);
      rd(4'h4, d); check("R12 second write hi", d, 8'hA5);
      check("R11 rdata idle at end", rdata, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule